// File: doc/BRIEF.md
# Fuse Word Read and Program Sequencer

This block is the command engine that sits between a register bus and a one-time-programmable fuse macro. Software supplies a 32-bit data word and a word address, and it enables programming by writing a four-character ASCII key. It then writes a four-character ASCII command word. The engine checks the command and starts a single fuse read or a single fuse program operation on the macro. It holds the request until the macro reports completion. A read result goes into the data register, and each kind of completion leaves a sticky flag that software clears.

The macro's programming time is not modelled inside the block. The macro may take any number of cycles before it raises its done strobe, and the engine just waits. Per-word write protection arrives on an input vector with one bit per fuse word, which a separate lock block drives. The three completion flags (load, read, write) are masked by matching enable bits and combined into one interrupt line. The load flag is set by a pulse from the reload logic outside this block.

Top module: `fuse_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, programming is disabled, the macro request is low and the interrupt is low.
- R2: Writing 0x4E45504F ("OPEN", little-endian ASCII) to offset 0x800 enables programming, and offset 0x800 then reads 1 in bit 0. Writing any other value there disables programming, and the offset reads 0.
- R3: Offset 0x808 holds a 7-bit word address, and its upper bits always read 0. Offset 0x804 is a 32-bit data register that software can read and write.
- R4: While the engine is idle, writing 0x44414552 ("READ") to offset 0x80C raises the macro request with the write select low and the address register on the macro address. When done arrives, the macro read data is stored in the data register and the read flag (bit 1 of offset 0xC00) is set.
- R5: While the engine is idle and programming is enabled, writing 0x574F4C42 ("BLOW") to offset 0x80C raises the macro request with the write select high, the data register on the write data and the address register on the address. When done arrives, the write flag (bit 2 of offset 0xC00) is set.
- R6: A "BLOW" written while programming is disabled, or aimed at a word whose lock input bit is 1, starts no macro request and leaves the write flag clear.
- R7: A command written while an operation is in progress is ignored, and so is any command word other than "READ" or "BLOW".
- R8: At offset 0xC00, bit 0 is the load flag, bit 1 the read flag and bit 2 the write flag. Writing 1 to a bit clears it, and writing 0 leaves it as it is. If a flag is set and cleared in the same cycle, the set wins.
- R9: A one-cycle pulse on the load-complete input sets the load flag.
- R10: Offset 0xC04 holds one enable per flag at the same bit positions. The interrupt output is high exactly when some flag and its enable are both 1.
- R11: The macro request, address, write select and write data stay constant from the command until the cycle in which done is sampled, whatever the done latency. The request then drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the offset on bus_addr |
| word_lock | input | 128 | Per-word program protection, 1 = locked |
| load_evt | input | 1 | One-cycle pulse that sets the load flag |
| fm_req | output | 1 | Request to the fuse macro |
| fm_wr | output | 1 | 1 = program, 0 = read |
| fm_addr | output | 7 | Fuse word address |
| fm_wdata | output | 32 | Data to program |
| fm_rdata | input | 32 | Data read from the macro, valid with done |
| fm_done | input | 1 | One-cycle completion strobe from the macro |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: a 7-bit address, so 128 words, and a 32-bit data word. With these values the highest word (127) and a word with its lock bit set can both be reached directly. The bench's fuse model answers after a latency that the bench sets per test, from zero cycles to several. This exercises the hold-until-done behaviour and the window in which a second command must be ignored.

// File: rtl/fce_pkg.sv
// Package: constants and types shared by the fuse command engine.
// Assumes little-endian packing of the four-character ASCII words.
package fce_pkg;
    localparam logic [31:0] KEY_OPEN = 32'h4E45504F;
    localparam logic [31:0] CMD_BLOW = 32'h574F4C42;
    localparam logic [31:0] CMD_READ = 32'h44414552;

    localparam logic [11:0] OFS_UNLOCK = 12'h800;
    localparam logic [11:0] OFS_DATA   = 12'h804;
    localparam logic [11:0] OFS_ADDR   = 12'h808;
    localparam logic [11:0] OFS_CMD    = 12'h80C;
    localparam logic [11:0] OFS_FLAG   = 12'hC00;
    localparam logic [11:0] OFS_IEN    = 12'hC04;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_LOAD  = 0;
    localparam int FLG_READ  = 1;
    localparam int FLG_WRITE = 2;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;
endpackage

// File: rtl/fce_regs.sv
// Module: software-visible unlock, address and data registers.
// Assumes one write strobe per cycle; a read completion overrides a
// same-cycle software write to the data register.
module fce_regs
    import fce_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_unlock,
    input  logic              wr_data,
    input  logic              wr_addr,
    input  logic [31:0]       wdata,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] fm_rdata,
    output logic              prog_en,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Programming enable follows the last value written to the unlock register.
    always_ff @(posedge clk) begin
        if (!rst_n)         prog_en <= 1'b0;
        else if (wr_unlock) prog_en <= (wdata == KEY_OPEN);
    end

    // Word address register, only the low bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (wr_addr) addr_q <= wdata[ADDR_W-1:0];
    end

    // Data register: macro read result has priority over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_done) data_q <= fm_rdata;
        else if (wr_data) data_q <= wdata[DATA_W-1:0];
    end

    // R4
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (data_q == $past(fm_rdata)));
endmodule

// File: rtl/fce_seq.sv
// Module: command sequencer driving the fuse macro handshake.
// Assumes the macro pulses done for one cycle while the request is high.
module fce_seq
    import fce_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    localparam int NUM_WORDS = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [31:0]          cmd_val,
    input  logic                 prog_en,
    input  logic [NUM_WORDS-1:0] word_lock,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic                 fm_done,
    output logic                 fm_req,
    output logic                 fm_wr,
    output logic [ADDR_W-1:0]    fm_addr,
    output logic [DATA_W-1:0]    fm_wdata,
    output logic                 rd_done,
    output logic                 wr_done
);
    seq_state_t state_q;
    logic       is_idle, start_rd, start_wr;

    // Command decode: only accepted while idle, BLOW also needs permission.
    always_comb begin
        is_idle  = (state_q == SEQ_IDLE);
        start_rd = cmd_wr && is_idle && (cmd_val == CMD_READ);
        start_wr = cmd_wr && is_idle && (cmd_val == CMD_BLOW)
                   && prog_en && !word_lock[addr_i];
    end

    // Operation state and latched operands, held until the macro finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            fm_wr    <= 1'b0;
            fm_addr  <= '0;
            fm_wdata <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start_rd || start_wr) begin
                    state_q  <= SEQ_RUN;
                    fm_wr    <= start_wr;
                    fm_addr  <= addr_i;
                    fm_wdata <= data_i;
                end
                SEQ_RUN: if (fm_done) state_q <= SEQ_IDLE;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Request and completion strobes derived from the state.
    always_comb begin
        fm_req  = (state_q == SEQ_RUN);
        rd_done = fm_req && fm_done && !fm_wr;
        wr_done = fm_req && fm_done &&  fm_wr;
    end

    // R11
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_req && !fm_done) |=> (fm_req && $stable(fm_addr)
                                  && $stable(fm_wdata) && $stable(fm_wr)));
    // R11
    drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_req && fm_done) |=> !fm_req);
endmodule

// File: rtl/fce_irq.sv
// Module: sticky write-1-to-clear completion flags, enables and interrupt.
// Assumes set events are single-cycle pulses; a set beats a clear.
module fce_irq
    import fce_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_flag,
    input  logic                 wr_ien,
    input  logic [NUM_FLAGS-1:0] wbits,
    input  logic                 load_evt,
    input  logic                 rd_done,
    input  logic                 wr_done,
    output logic [NUM_FLAGS-1:0] flags_q,
    output logic [NUM_FLAGS-1:0] ien_q,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] set_vec;

    // Gather the per-flag set events by bit position.
    always_comb begin
        set_vec            = '0;
        set_vec[FLG_LOAD]  = load_evt;
        set_vec[FLG_READ]  = rd_done;
        set_vec[FLG_WRITE] = wr_done;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            // One sticky flag: set wins, otherwise a written 1 clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)                     flags_q[i] <= 1'b0;
                else if (set_vec[i])            flags_q[i] <= 1'b1;
                else if (wr_flag && wbits[i])   flags_q[i] <= 1'b0;
            end

            // R8
            flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[i] && !(wr_flag && wbits[i])) |=> flags_q[i]);
            // R8
            flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_flag && wbits[i] && !set_vec[i]) |=> !flags_q[i]);
            // R9
            flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> flags_q[i]);
        end
    endgenerate

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wbits;
    end

    // Interrupt line: any enabled flag.
    always_comb irq = |(flags_q & ien_q);
endmodule

// File: rtl/fuse_cmd_engine.sv
// Module: top of the fuse word read/program command engine.
// Assumes a simple register bus with combinational read data and a fuse
// macro with a request/done handshake of arbitrary latency.
module fuse_cmd_engine
    import fce_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int BUS_AW = 12,
    localparam int NUM_WORDS = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_WORDS-1:0] word_lock,
    input  logic                 load_evt,
    output logic                 fm_req,
    output logic                 fm_wr,
    output logic [ADDR_W-1:0]    fm_addr,
    output logic [DATA_W-1:0]    fm_wdata,
    input  logic [DATA_W-1:0]    fm_rdata,
    input  logic                 fm_done,
    output logic                 irq
);
    logic                 sel_unlock, sel_data, sel_addr, sel_cmd, sel_flag, sel_ien;
    logic                 prog_en, rd_done, wr_done;
    logic [DATA_W-1:0]    data_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_FLAGS-1:0] flags_q, ien_q;
    logic                 lock_sel;

    // Offset decode of the register bus.
    always_comb begin
        sel_unlock = (bus_addr == BUS_AW'(OFS_UNLOCK));
        sel_data   = (bus_addr == BUS_AW'(OFS_DATA));
        sel_addr   = (bus_addr == BUS_AW'(OFS_ADDR));
        sel_cmd    = (bus_addr == BUS_AW'(OFS_CMD));
        sel_flag   = (bus_addr == BUS_AW'(OFS_FLAG));
        sel_ien    = (bus_addr == BUS_AW'(OFS_IEN));
        lock_sel   = word_lock[addr_q];
    end

    fce_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_unlock(bus_wr && sel_unlock), .wr_data(bus_wr && sel_data),
        .wr_addr(bus_wr && sel_addr), .wdata(bus_wdata),
        .rd_done(rd_done), .fm_rdata(fm_rdata),
        .prog_en(prog_en), .data_q(data_q), .addr_q(addr_q)
    );

    fce_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(bus_wr && sel_cmd), .cmd_val(bus_wdata),
        .prog_en(prog_en), .word_lock(word_lock),
        .addr_i(addr_q), .data_i(data_q), .fm_done(fm_done),
        .fm_req(fm_req), .fm_wr(fm_wr), .fm_addr(fm_addr), .fm_wdata(fm_wdata),
        .rd_done(rd_done), .wr_done(wr_done)
    );

    fce_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_flag(bus_wr && sel_flag), .wr_ien(bus_wr && sel_ien),
        .wbits(bus_wdata[NUM_FLAGS-1:0]),
        .load_evt(load_evt), .rd_done(rd_done), .wr_done(wr_done),
        .flags_q(flags_q), .ien_q(ien_q), .irq(irq)
    );

    // Read-back multiplexer; the command register reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_unlock)    bus_rdata[0]                = prog_en;
        else if (sel_data) bus_rdata[DATA_W-1:0]       = data_q;
        else if (sel_addr) bus_rdata[ADDR_W-1:0]       = addr_q;
        else if (sel_flag) bus_rdata[NUM_FLAGS-1:0]    = flags_q;
        else if (sel_ien)  bus_rdata[NUM_FLAGS-1:0]    = ien_q;
    end

    // R6
    blow_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fm_req) && fm_wr) |-> ($past(prog_en) && !$past(lock_sel)));
    // R4
    read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fm_req) |-> (fm_addr == $past(addr_q)));
endmodule

// File: tb/fuse_cmd_engine_bench.sv
module fuse_cmd_engine_bench;
    localparam logic [31:0] K_OPEN = 32'h4E45504F;
    localparam logic [31:0] K_BLOW = 32'h574F4C42;
    localparam logic [31:0] K_READ = 32'h44414552;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] word_lock = '0;
    logic         load_evt = 1'b0;
    logic         fm_req, fm_wr;
    logic [6:0]   fm_addr;
    logic [31:0]  fm_wdata;
    logic [31:0]  fm_rdata = '0;
    logic         fm_done = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int cnt = 0;
    int req_rises = 0;
    logic req_d = 1'b0;
    logic [31:0] mem [128];

    always #2 clk = ~clk;

    fuse_cmd_engine u_fuse_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_lock(word_lock),
        .load_evt(load_evt), .fm_req(fm_req), .fm_wr(fm_wr), .fm_addr(fm_addr),
        .fm_wdata(fm_wdata), .fm_rdata(fm_rdata), .fm_done(fm_done), .irq(irq)
    );

    // Fuse macro model with a configurable done latency.
    always @(posedge clk) begin
        req_d <= fm_req;
        if (fm_req && !req_d) req_rises <= req_rises + 1;
        if (fm_req && !fm_done) begin
            if (cnt >= lat) begin
                fm_done  <= 1'b1;
                fm_rdata <= mem[fm_addr];
                if (fm_wr) mem[fm_addr] <= fm_wdata;
                cnt <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            fm_done <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && fm_req; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bread(12'h800, v); check("R1 unlock", v, 0);
        bread(12'h804, v); check("R1 data", v, 0);
        bread(12'h808, v); check("R1 addr", v, 0);
        bread(12'hC00, v); check("R1 flags", v, 0);
        bread(12'hC04, v); check("R1 ien", v, 0);
        check("R1 req", {31'b0, fm_req}, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bwrite(12'h808, 32'hFFFF_FFFF);
        bread(12'h808, v); check("R3 addr mask", v, 32'h7F);
        bwrite(12'h804, 32'hDEAD_BEEF);
        bread(12'h804, v); check("R3 data rw", v, 32'hDEAD_BEEF);
        bwrite(12'h800, K_OPEN);
        bread(12'h800, v); check("R2 unlock open", v, 1);
        bwrite(12'h800, 32'h4E45504E);
        bread(12'h800, v); check("R2 relock", v, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        lat = 3;
        mem[5] = 32'hCAFE_0005;
        bwrite(12'h808, 5);
        bwrite(12'h80C, K_READ);
        check("R4 req", {31'b0, fm_req}, 1);
        check("R4 wr sel", {31'b0, fm_wr}, 0);
        check("R4 addr", {25'b0, fm_addr}, 5);
        wait_idle();
        bread(12'h804, v); check("R4 data", v, 32'hCAFE_0005);
        bread(12'hC00, v); check("R4 read flag", v, 32'h2);
        bwrite(12'hC00, 32'h0);
        bread(12'hC00, v); check("R8 write zero keeps", v, 32'h2);
        bwrite(12'hC00, 32'h2);
        bread(12'hC00, v); check("R8 w1c", v, 0);
    endtask

    task automatic t_blow();
        logic [31:0] v;
        int held = 0;
        int unstable = 0;
        lat = 5;
        bwrite(12'h800, K_OPEN);
        bwrite(12'h808, 127);
        bwrite(12'h804, 32'h1234_5678);
        bwrite(12'h80C, K_BLOW);
        check("R5 wr sel", {31'b0, fm_wr}, 1);
        check("R5 wdata", fm_wdata, 32'h1234_5678);
        for (int i = 0; i < 50 && fm_req; i++) begin
            held++;
            if (fm_addr != 7'd127 || fm_wdata != 32'h1234_5678 || !fm_wr) unstable++;
            @(negedge clk);
        end
        check("R11 hold cycles", held, lat + 2);
        check("R11 stable", unstable, 0);
        check("R5 fuse written", mem[127], 32'h1234_5678);
        bread(12'hC00, v); check("R5 write flag", v, 32'h4);
        bwrite(12'hC00, 32'h7);
        lat = 0;
        bwrite(12'h80C, K_READ);
        wait_idle();
        bread(12'h804, v); check("R11 zero latency read", v, 32'h1234_5678);
        bwrite(12'hC00, 32'h7);
    endtask

    task automatic t_blow_denied();
        logic [31:0] v;
        int r0;
        lat = 1;
        mem[10] = 32'h0000_000A;
        bwrite(12'h800, 32'h0);
        bwrite(12'h808, 10);
        bwrite(12'h804, 32'hFFFF_FFFF);
        r0 = req_rises;
        bwrite(12'h80C, K_BLOW);
        repeat (4) @(negedge clk);
        check("R6 locked no req", req_rises - r0, 0);
        bread(12'hC00, v); check("R6 locked flag", v, 0);
        bwrite(12'h800, K_OPEN);
        word_lock[10] = 1'b1;
        bwrite(12'h80C, K_BLOW);
        repeat (4) @(negedge clk);
        check("R6 word lock no req", req_rises - r0, 0);
        check("R6 fuse intact", mem[10], 32'h0000_000A);
        bread(12'hC00, v); check("R6 word lock flag", v, 0);
        word_lock[10] = 1'b0;
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        int r0;
        lat = 6;
        mem[20] = 32'h0000_0014;
        bwrite(12'h800, K_OPEN);
        bwrite(12'h808, 5);
        r0 = req_rises;
        bwrite(12'h80C, K_READ);
        bwrite(12'h808, 20);
        bwrite(12'h80C, K_BLOW);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R7 one request", req_rises - r0, 1);
        check("R7 fuse intact", mem[20], 32'h0000_0014);
        bread(12'hC00, v); check("R7 only read flag", v, 32'h2);
        bwrite(12'hC00, 32'h7);
        bwrite(12'h80C, 32'h1234_5678);
        repeat (3) @(negedge clk);
        check("R7 unknown cmd", req_rises - r0, 1);
        bread(12'hC00, v); check("R7 unknown flags", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        lat = 0;
        bwrite(12'h808, 3);
        bwrite(12'h80C, K_READ);
        wait_idle();
        check("R10 masked", {31'b0, irq}, 0);
        bwrite(12'hC04, 32'h2);
        bread(12'hC04, v); check("R10 ien rb", v, 32'h2);
        check("R10 enabled", {31'b0, irq}, 1);
        bwrite(12'hC04, 32'h5);
        check("R10 other mask", {31'b0, irq}, 0);
        @(negedge clk); load_evt = 1'b1;
        @(negedge clk); load_evt = 1'b0;
        bread(12'hC00, v); check("R9 load flag", v, 32'h3);
        check("R10 load irq", {31'b0, irq}, 1);
        bwrite(12'hC00, 32'h3);
        check("R10 cleared", {31'b0, irq}, 0);
        // set and clear of the load flag in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'hC00; bus_wdata = 32'h1; load_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; load_evt = 1'b0;
        bread(12'hC00, v); check("R8 set wins", v, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'hA500_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_read();
        t_blow();
        t_blow_denied();
        t_ignore();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule